// File: doc/BRIEF.md
# Partial-Tag Set-Associative Branch Target Buffer

This block predicts where a taken branch will go. A fetch unit presents the current fetch PC on the lookup port. In the same cycle the block reports whether a matching entry exists, the predicted next PC, and whether the matching branch is a subroutine return. When a branch resolves as taken, the branch PC, its target and its return flag come in on the update port. The block then either refreshes the entry that already holds that branch or allocates a new one in the indexed set.

Storage is kept small on purpose, so a prediction can be wrong:

- Only ten PC bits are kept as the tag. Two branches whose PCs differ only above those bits share an entry.
- Only the low 24 bits of the target are stored. The upper 8 bits of the predicted target are copied from the lookup PC.

A wrong prediction is caught and repaired further down the pipeline, so it costs performance but never correctness. Entries are placed by a round-robin pointer kept for each set. A single-cycle synchronous flush invalidates every entry.

Top module: `btb_partial`

## Requirements
- R1: After reset every entry is invalid and every lookup misses.
- R2: On a miss, `lkHit` is 0, `lkTarget` equals `lkPc + 4` and `lkIsRet` is 0.
- R3: An update with `updValid` high (and no flush) writes the branch. From the next cycle, a lookup of the same PC hits and returns `{lkPc[31:24], updTarget[23:0]}` and the stored return flag.
- R4: The set index is PC[7:2] and the tag is PC[17:8]. A lookup PC that differs from a stored branch only in bits [31:18] or [1:0] hits that entry, and the target's bits [31:24] come from the lookup PC.
- R5: Each of the 64 sets holds four branches with distinct tags at the same time.
- R6: An update that misses in its set writes the way named by that set's pointer, then advances the pointer. The pointer starts at way 0 and wraps after way 3, so the oldest allocation is the one evicted.
- R7: An update whose tag already sits in the set overwrites that way (target and return flag) and leaves the set's pointer unchanged.
- R8: A lookup and an update in the same cycle: the lookup returns the contents as they were before that update.
- R9: `flush` clears all valid bits at the clock edge and also resets the pointers. An update in the same cycle as a flush is dropped.
- R10: An update to one set does not change lookups that index another set.
- R11: Values on the update port while `updValid` is low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous invalidate of all entries |
| lkPc | input | 32 | Fetch PC to look up |
| lkHit | output | 1 | Valid entry with matching tag found |
| lkTarget | output | 32 | Predicted next PC |
| lkIsRet | output | 1 | Matching entry is marked as a return |
| updValid | input | 1 | A resolved taken branch is presented |
| updPc | input | 32 | Address of the resolved branch |
| updTarget | input | 32 | Resolved target address |
| updIsRet | input | 1 | The resolved branch is a return |

## Verification
All branches in the replacement and overwrite tests share one set. They are loaded in a fixed order, so the round-robin victim can be told apart from other plausible policies:

- the victim must be the oldest allocation, not the most recent one;
- a refreshed entry must not have advanced the pointer.

An aliasing PC that shares only the index and tag bits shows that the upper target bits come from the lookup PC and not from the stored entry. Lookups made in the same cycle as an update, or as a flush, separate read-before-write behaviour from write-through. An update that arrives together with a flush shows that the flush takes priority.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Strobes from control to datapath for one clock edge.
  typedef struct packed {
    logic wrEn;     // write the selected way of the update set
    logic flushAll; // clear every valid bit
    logic advPtr;   // allocation: advance the set's round-robin pointer
  } btbStrobe_t;
endpackage

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int TAG_W = 10,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        flush,
  input  logic                        updValid,
  input  logic [IDX_W-1:0]            updIdx,
  input  logic [TAG_W-1:0]            updTag,
  input  logic [TAG_W-1:0]            lkTag,
  input  logic [WAYS-1:0]             lkSetValid,
  input  logic [WAYS-1:0][TAG_W-1:0]  lkSetTag,
  input  logic [WAYS-1:0]             updSetValid,
  input  logic [WAYS-1:0][TAG_W-1:0]  updSetTag,
  output logic [WAYS-1:0]             lkWayHit,
  output logic [WAY_W-1:0]            updWay,
  output btbStrobe_t                  strobe
);
  logic [WAYS-1:0]  updWayHit;
  logic             updHitAny;
  logic [WAY_W-1:0] updHitIdx;
  logic [WAY_W-1:0] rrPtr [SETS];

  // Parallel tag compare for every way of both indexed sets.
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lkWayHit[w]  = lkSetValid[w]  && (lkSetTag[w]  == lkTag);
    assign updWayHit[w] = updSetValid[w] && (updSetTag[w] == updTag);
  end

  assign updHitAny = |updWayHit;

  always_comb begin
    updHitIdx = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (updWayHit[w]) updHitIdx = WAY_W'(w);
    end
  end

  // A refresh reuses the way that already holds the tag; otherwise the pointer picks.
  assign updWay = updHitAny ? updHitIdx : rrPtr[updIdx];

  always_comb begin
    strobe.flushAll = flush;
    strobe.wrEn     = updValid && !flush;
    strobe.advPtr   = updValid && !flush && !updHitAny;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) rrPtr[s] <= '0;
    end else if (strobe.flushAll) begin
      for (int s = 0; s < SETS; s++) rrPtr[s] <= '0;
    end else if (strobe.advPtr) begin
      rrPtr[updIdx] <= (rrPtr[updIdx] == WAY_W'(WAYS - 1)) ? '0 : rrPtr[updIdx] + 1'b1;
    end
  end
endmodule

// File: rtl/btb_data.sv
module btb_data
  import btb_pkg::*;
#(
  parameter int SETS       = 64,
  parameter int WAYS       = 4,
  parameter int TAG_W      = 10,
  parameter int TGT_W      = 24,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  btbStrobe_t                  strobe,
  input  logic [IDX_W-1:0]            updIdx,
  input  logic [WAY_W-1:0]            updWay,
  input  logic [TAG_W-1:0]            updTag,
  input  logic [TGT_W-1:0]            updTgtLow,
  input  logic                        updRet,
  input  logic [IDX_W-1:0]            lkIdx,
  input  logic [PC_W-1:0]             lkPc,
  input  logic [WAYS-1:0]             lkWayHit,
  output logic [WAYS-1:0]             lkSetValid,
  output logic [WAYS-1:0][TAG_W-1:0]  lkSetTag,
  output logic [WAYS-1:0]             updSetValid,
  output logic [WAYS-1:0][TAG_W-1:0]  updSetTag,
  output logic                        lkHit,
  output logic [PC_W-1:0]             lkTarget,
  output logic                        lkIsRet
);
  logic [WAYS-1:0]  validQ [SETS];
  logic [TAG_W-1:0] tagQ   [SETS][WAYS];
  logic [TGT_W-1:0] tgtQ   [SETS][WAYS];
  logic             retQ   [SETS][WAYS];

  logic [TGT_W-1:0] selTgt;
  logic             selRet;

  assign lkSetValid  = validQ[lkIdx];
  assign updSetValid = validQ[updIdx];
  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign lkSetTag[w]  = tagQ[lkIdx][w];
    assign updSetTag[w] = tagQ[updIdx][w];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) validQ[s] <= '0;
    end else if (strobe.flushAll) begin
      for (int s = 0; s < SETS; s++) validQ[s] <= '0;
    end else if (strobe.wrEn) begin
      validQ[updIdx][updWay] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      tagQ[updIdx][updWay] <= updTag;
      tgtQ[updIdx][updWay] <= updTgtLow;
      retQ[updIdx][updWay] <= updRet;
    end
  end

  // AND-OR select: at most one way matches, since a refresh never duplicates a tag.
  always_comb begin
    selTgt = '0;
    selRet = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (lkWayHit[w]) begin
        selTgt = selTgt | tgtQ[lkIdx][w];
        selRet = selRet | retQ[lkIdx][w];
      end
    end
  end

  assign lkHit    = |lkWayHit;
  assign lkTarget = lkHit ? {lkPc[PC_W-1:TGT_W], selTgt} : lkPc + PC_W'(INST_BYTES);
  assign lkIsRet  = lkHit && selRet;
endmodule

// File: rtl/btb_partial.sv
module btb_partial
  import btb_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int SETS       = 64,
  parameter int WAYS       = 4,
  parameter int TAG_W      = 10,
  parameter int TGT_W      = 24,
  parameter int INST_BYTES = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            flush,
  input  logic [PC_W-1:0] lkPc,
  output logic            lkHit,
  output logic [PC_W-1:0] lkTarget,
  output logic            lkIsRet,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic [PC_W-1:0] updTarget,
  input  logic            updIsRet
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int IDX_LO = $clog2(INST_BYTES);
  localparam int TAG_LO = IDX_LO + IDX_W;

  logic [IDX_W-1:0]           lkIdx, updIdx;
  logic [TAG_W-1:0]           lkTag, updTag;
  logic [WAYS-1:0]            lkSetValid, updSetValid, lkWayHit;
  logic [WAYS-1:0][TAG_W-1:0] lkSetTag, updSetTag;
  logic [WAY_W-1:0]           updWay;
  btbStrobe_t                 strobe;
  logic                       unusedBits;

  assign lkIdx  = lkPc[IDX_LO +: IDX_W];
  assign lkTag  = lkPc[TAG_LO +: TAG_W];
  assign updIdx = updPc[IDX_LO +: IDX_W];
  assign updTag = updPc[TAG_LO +: TAG_W];
  assign unusedBits = ^{updPc, updTarget[PC_W-1:TGT_W]};

  btb_ctrl #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .flush(flush), .updValid(updValid),
    .updIdx(updIdx), .updTag(updTag), .lkTag(lkTag),
    .lkSetValid(lkSetValid), .lkSetTag(lkSetTag),
    .updSetValid(updSetValid), .updSetTag(updSetTag),
    .lkWayHit(lkWayHit), .updWay(updWay), .strobe(strobe)
  );

  btb_data #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .TGT_W(TGT_W),
             .PC_W(PC_W), .INST_BYTES(INST_BYTES)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .updIdx(updIdx), .updWay(updWay), .updTag(updTag),
    .updTgtLow(updTarget[TGT_W-1:0]), .updRet(updIsRet),
    .lkIdx(lkIdx), .lkPc(lkPc), .lkWayHit(lkWayHit),
    .lkSetValid(lkSetValid), .lkSetTag(lkSetTag),
    .updSetValid(updSetValid), .updSetTag(updSetTag),
    .lkHit(lkHit), .lkTarget(lkTarget), .lkIsRet(lkIsRet)
  );
endmodule

// File: rtl/btb_partial_check.sv
module btb_partial_check #(
  parameter int PC_W       = 32,
  parameter int WAYS       = 4,
  parameter int TGT_W      = 24,
  parameter int INST_BYTES = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            flush,
  input logic [PC_W-1:0] lkPc,
  input logic            lkHit,
  input logic [PC_W-1:0] lkTarget,
  input logic            lkIsRet,
  input logic            updValid,
  input logic [PC_W-1:0] updPc,
  input logic [PC_W-1:0] updTarget,
  input logic            updIsRet,
  input logic [WAYS-1:0] lkWayHit
);
  logic unusedChk;
  assign unusedChk = ^updTarget[PC_W-1:TGT_W];

  // R5 / R7: a tag lives in at most one way of a set.
  p_single_way_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkWayHit));

  // R2: a miss predicts the sequential PC and no return.
  p_miss_seq_r2: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (lkTarget == lkPc + PC_W'(INST_BYTES)) && !lkIsRet);

  // R4: on a hit, the upper target bits follow the lookup PC.
  p_upper_from_pc_r4: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> lkTarget[PC_W-1:TGT_W] == lkPc[PC_W-1:TGT_W]);

  // R3: a written branch is visible to a lookup of the same PC one cycle later.
  p_write_then_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !flush) |=> (lkPc != $past(updPc)) ||
      (lkHit && lkTarget[TGT_W-1:0] == $past(updTarget[TGT_W-1:0])
             && lkIsRet == $past(updIsRet)));

  // R9: after a flush edge nothing hits.
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !lkHit);
endmodule

bind btb_partial btb_partial_check #(.PC_W(PC_W), .WAYS(WAYS), .TGT_W(TGT_W),
                                     .INST_BYTES(INST_BYTES)) uChk (.*);

// File: tb/btb_partial_test.sv
module btb_partial_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] lkPc = '0;
  logic        lkHit;
  logic [31:0] lkTarget;
  logic        lkIsRet;
  logic        updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic [31:0] updTarget = '0;
  logic        updIsRet = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  btb_partial uut (
    .clk(clk), .rstN(rstN), .flush(flush), .lkPc(lkPc),
    .lkHit(lkHit), .lkTarget(lkTarget), .lkIsRet(lkIsRet),
    .updValid(updValid), .updPc(updPc), .updTarget(updTarget), .updIsRet(updIsRet)
  );

  typedef struct packed {
    logic        uv;
    logic [31:0] upc;
    logic [31:0] utg;
    logic        ur;
    logic [31:0] lpc;
    logic        eh;
    logic [31:0] et;
    logic        er;
    logic [7:0]  req;
  } vec_t;

  // All of A..F index set 5 (PC[7:2]=5) with tags 1..6 (PC[17:8]); G indexes set 6.
  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_0114, 1'b0, 32'h0000_0118, 1'b0, 8'd2},              // R2 empty
    '{1'b1, 32'h0000_0114, 32'h00AA_1000, 1'b0, 32'h0000_0114, 1'b0, 32'h0000_0118, 1'b0, 8'd8}, // R8 write A
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_0114, 1'b1, 32'h00AA_1000, 1'b0, 8'd3},              // R3
    '{1'b1, 32'h0000_0214, 32'h00BB_2000, 1'b1, 32'hAB04_0114, 1'b1, 32'hABAA_1000, 1'b0, 8'd4}, // R4 alias
    '{1'b1, 32'h0000_0314, 32'h00CC_3000, 1'b0, 32'h0000_0214, 1'b1, 32'h00BB_2000, 1'b1, 8'd3},
    '{1'b1, 32'h0000_0414, 32'h00DD_4000, 1'b0, 32'h0000_0314, 1'b1, 32'h00CC_3000, 1'b0, 8'd5},
    '{1'b1, 32'h0000_0214, 32'h00B0_5000, 1'b0, 32'h0000_0414, 1'b1, 32'h00DD_4000, 1'b0, 8'd5}, // refresh B
    '{1'b1, 32'h0000_0514, 32'h00EE_6000, 1'b0, 32'h0000_0214, 1'b1, 32'h00B0_5000, 1'b0, 8'd7}, // R7, E evicts A
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_0114, 1'b0, 32'h0000_0118, 1'b0, 8'd6},              // R6 A gone
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_0514, 1'b1, 32'h00EE_6000, 1'b0, 8'd6},
    '{1'b1, 32'h0000_0614, 32'h00FF_7000, 1'b1, 32'h0000_0214, 1'b1, 32'h00B0_5000, 1'b0, 8'd8}, // R8, F evicts B
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_0214, 1'b0, 32'h0000_0218, 1'b0, 8'd6},              // R6 B gone
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_0614, 1'b1, 32'h00FF_7000, 1'b1, 8'd3},
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_0314, 1'b1, 32'h00CC_3000, 1'b0, 8'd5},
    '{1'b1, 32'h0000_0118, 32'h0012_3400, 1'b0, 32'h0000_0414, 1'b1, 32'h00DD_4000, 1'b0, 8'd10},
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_0118, 1'b1, 32'h0012_3400, 1'b0, 8'd10},             // R10
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_0114, 1'b0, 32'h0000_0118, 1'b0, 8'd10},
    '{1'b0, 32'h0000_0714, 32'h0077_7000, 1'b1, 32'h0000_0414, 1'b1, 32'h00DD_4000, 1'b0, 8'd11}, // R11 idle data
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_0714, 1'b0, 32'h0000_0718, 1'b0, 8'd11}
  };

  task automatic chk(input string req, input logic eh, input logic [31:0] et, input logic er);
    checks++;
    if (lkHit !== eh || lkTarget !== et || lkIsRet !== er) begin
      failures++;
      $display("FAIL %s pc=%h got hit=%b tgt=%h ret=%b exp hit=%b tgt=%h ret=%b",
               req, lkPc, lkHit, lkTarget, lkIsRet, eh, et, er);
    end
  endtask

  task automatic drive(input logic uv, input logic [31:0] upc, input logic [31:0] utg,
                       input logic ur, input logic fl, input logic [31:0] lpc);
    @(negedge clk);
    updValid = uv; updPc = upc; updTarget = utg; updIsRet = ur; flush = fl; lkPc = lpc;
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: empty after reset, at two sets
    drive(1'b0, '0, '0, 1'b0, 1'b0, 32'h0000_0114);
    chk("R1", 1'b0, 32'h0000_0118, 1'b0);
    drive(1'b0, '0, '0, 1'b0, 1'b0, 32'hFFFF_FFFC);
    chk("R1", 1'b0, 32'h0000_0000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].uv, VECS[i].upc, VECS[i].utg, VECS[i].ur, 1'b0, VECS[i].lpc);
      chk($sformatf("R%0d", VECS[i].req), VECS[i].eh, VECS[i].et, VECS[i].er);
    end

    // R9: flush with a simultaneous update; lookup this cycle still sees old contents
    drive(1'b1, 32'h0000_0714, 32'h0077_7000, 1'b0, 1'b1, 32'h0000_0514);
    chk("R9", 1'b1, 32'h00EE_6000, 1'b0);
    drive(1'b0, '0, '0, 1'b0, 1'b0, 32'h0000_0514);
    chk("R9", 1'b0, 32'h0000_0518, 1'b0);
    drive(1'b0, '0, '0, 1'b0, 1'b0, 32'h0000_0118);
    chk("R9", 1'b0, 32'h0000_011C, 1'b0);
    drive(1'b0, '0, '0, 1'b0, 1'b0, 32'h0000_0714);
    chk("R9", 1'b0, 32'h0000_0718, 1'b0);
    // R3: writes work again after a flush
    drive(1'b1, 32'h0000_0114, 32'h0055_5000, 1'b1, 1'b0, 32'h0000_0114);
    chk("R8", 1'b0, 32'h0000_0118, 1'b0);
    drive(1'b0, '0, '0, 1'b0, 1'b0, 32'h1200_0114);
    chk("R3", 1'b1, 32'h1255_5000, 1'b1);
    // R1: a new reset empties the table
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    drive(1'b0, '0, '0, 1'b0, 1'b0, 32'h0000_0114);
    chk("R1", 1'b0, 32'h0000_0118, 1'b0);

    finish_run();
  end
endmodule